// File: doc/BRIEF.md
# Floppy Read Byte Assembler with Sync Detection

The block receives the raw bit stream recovered from a floppy read head, one bit on each strobe, and packs those bits into bytes. When eight bits have arrived it raises a one-clock byte-ready pulse. That pulse is wired to the host processor's set-overflow input, so firmware can clear the overflow flag and branch on it in a tight loop until the next byte shows up. The finished byte is latched on a data read port, where it stays until the next byte completes.

A second function watches the undecoded stream for a long run of one bits. Encoded data can never contain such a run, so it marks the start of a header or data block. The block has no index-hole input, and these marks are the only way to find where sectors begin. Firmware learns of a mark by polling the top bit of a status port. While the mark lasts, byte assembly is held at bit zero. The zero bit that ends the mark becomes the first bit of the next byte, so bytes line up with the end of the mark.

Top module: `disk_rd_shifter`

## Requirements
- R1: A synchronous active-high reset clears the data port, the status port, the byte-ready output and the internal bit counter and run counter.
- R2: `byte_ready` is high for exactly one clock, in the cycle after the strobe that delivers the eighth counted bit. Counting starts at reset or at the end of the previous byte.
- R3: The bit received first in a byte is stored in `data_port` bit 7 and the last in bit 0, so the byte is filled MSB first.
- R4: `data_port` takes the new byte in the same cycle that `byte_ready` is high, and it does not change in any other cycle.
- R5: `status_port` bit 7 (sync) goes to 1 in the cycle after the strobe that delivers the tenth consecutive one bit. A run of nine ones leaves it at 0.
- R6: Once set, sync stays at 1 for further one bits. It returns to 0 in the cycle after the strobe that delivers a zero bit.
- R7: While sync is 1, no `byte_ready` pulse occurs and the bit counter stays at zero. The zero bit that clears sync is counted as the first bit of the next byte.
- R8: `status_port` bits 6 to 0 always read 0.
- R9: A clock cycle without `bit_stb` high changes neither port, and it produces no `byte_ready` pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-clock strobe: `bit_val` holds a new raw bit |
| bit_val | input | 1 | Raw bit recovered from the read head |
| byte_ready | output | 1 | One-clock pulse to the processor's set-overflow input |
| status_port | output | 8 | Status read port; bit 7 is the sync flag |
| data_port | output | 8 | Last assembled byte |

## Verification
The assertions assume that `bit_stb` is a single-clock pulse with `bit_val` valid in the same cycle. They also assume that strobes never come closer than one per clock, so eight strobes always separate two byte-ready pulses. The bench drives each strobe for exactly one clock and follows it with at least one idle clock. It then sweeps every byte value, together with one-runs of nine, ten and more bits, so that both the sync boundary and the interplay of runs that cross byte edges stay within that assumption.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
    // Position of the sync flag inside the status port (firmware polls it as the sign bit)
    localparam int STATUS_W   = 8;
    localparam int SYNC_POS   = 7;

    function automatic logic [STATUS_W-1:0] pack_status(input logic sync_flag);
        logic [STATUS_W-1:0] v;
        v           = '0;
        v[SYNC_POS] = sync_flag;
        return v;
    endfunction
endpackage

// File: rtl/dsk_run_detect.sv
module dsk_run_detect #(
    parameter int RUN_LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic bit_in,
    output logic sync_now,   // sync state after this cycle's bit
    output logic sync_q
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             sync;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stb) begin
            if (bit_in) begin
                if (s_q.run != RUN_MAX) s_d.run = s_q.run + 1'b1;
            end else begin
                s_d.run = '0;
            end
            s_d.sync = (s_d.run == RUN_MAX);
        end
        sync_now = s_d.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign sync_q = s_q.sync;

    // R5
    sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.sync) |-> $past(stb && bit_in));
    // R6
    sync_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(s_q.sync) |-> $past(stb && !bit_in));
endmodule

// File: rtl/dsk_byte_pack.sv
module dsk_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              bit_in,
    input  logic              hold,
    output logic              rdy_q,
    output logic [BYTE_W-1:0] data_q
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              rdy;
        logic [BYTE_W-1:0] data;
    } bp_state_t;

    bp_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b0;
        if (stb) begin
            if (hold) begin
                s_d.cnt   = '0;
                s_d.shreg = '0;
            end else begin
                s_d.shreg = {s_q.shreg[BYTE_W-2:0], bit_in};
                if (s_q.cnt == LAST) begin
                    s_d.cnt  = '0;
                    s_d.rdy  = 1'b1;
                    s_d.data = s_d.shreg;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rdy_q  = s_q.rdy;
    assign data_q = s_q.data;

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.rdy |=> !s_q.rdy);
    // R7
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        $past(stb && hold) |-> (s_q.cnt == '0) && !s_q.rdy);
endmodule

// File: rtl/dsk_status_port.sv
module dsk_status_port (
    input  logic                         sync_flag,
    output logic [dsk_pkg::STATUS_W-1:0] status
);
    always_comb status = dsk_pkg::pack_status(sync_flag);
endmodule

// File: rtl/disk_rd_shifter.sv
module disk_rd_shifter #(
    parameter int BYTE_W  = 8,
    parameter int RUN_LEN = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              byte_ready,
    output logic [7:0]        status_port,
    output logic [BYTE_W-1:0] data_port
);
    logic sync_now;
    logic sync_q;

    dsk_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(clk), .rst(rst), .stb(bit_stb), .bit_in(bit_val),
        .sync_now(sync_now), .sync_q(sync_q)
    );

    dsk_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst(rst), .stb(bit_stb), .bit_in(bit_val),
        .hold(sync_now), .rdy_q(byte_ready), .data_q(data_port)
    );

    dsk_status_port u_stat (
        .sync_flag(sync_q), .status(status_port)
    );

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_ready |-> $stable(data_port));
    // R7
    ready_sync_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_q && $past(sync_q)) |-> !byte_ready);
    // R9
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_stb) |-> !byte_ready && $stable(status_port));
    // R8
    status_low_chk: assert property (@(posedge clk) disable iff (rst)
        status_port[6:0] == 7'd0);
endmodule

// File: tb/sim_disk_rd_shifter.sv
module sim_disk_rd_shifter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       bit_val = 1'b0;
    logic       byte_ready;
    logic [7:0] status_port;
    logic [7:0] data_port;

    int checks = 0;
    int errors = 0;

    // expected-state model
    int         run = 0;
    int         cnt = 0;
    logic [7:0] sh = 8'h00;
    logic [7:0] e_data = 8'h00;
    logic       e_sync = 1'b0;
    logic       e_rdy = 1'b0;

    always #2.5 clk = ~clk;

    disk_rd_shifter u0 (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
        .byte_ready(byte_ready), .status_port(status_port), .data_port(data_port)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_ports();
        chk(byte_ready == e_rdy, "R2/R7 byte_ready", byte_ready, e_rdy);
        chk(data_port == e_data, "R3/R4 data_port", data_port, e_data);
        chk(status_port[7] == e_sync, "R5/R6 sync", status_port[7], e_sync);
        chk(status_port[6:0] == 7'd0, "R8 status low bits", status_port[6:0], 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            e_rdy = 1'b0;
            // R9: no strobe, nothing moves
            check_ports();
        end
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_val = b;
        if (b) begin
            if (run < 10) run++;
        end else run = 0;
        e_rdy = 1'b0;
        if (run >= 10) begin
            cnt = 0;
            sh  = 8'h00;
        end else begin
            sh = {sh[6:0], b};
            if (cnt == 7) begin
                cnt = 0;
                e_rdy = 1'b1;
                e_data = sh;
            end else cnt++;
        end
        e_sync = (run >= 10);
        @(negedge clk);
        bit_stb = 1'b0;
        check_ports();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send(v[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        run = 0; cnt = 0; sh = 8'h00; e_data = 8'h00; e_sync = 1'b0; e_rdy = 1'b0;
        // R1
        chk(byte_ready == 1'b0, "R1 byte_ready", byte_ready, 0);
        chk(data_port == 8'h00, "R1 data_port", data_port, 0);
        chk(status_port == 8'h00, "R1 status_port", status_port, 0);
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        idle(2);
        // R3: plain bytes right after reset, MSB first
        send_byte(8'hA5);
        idle(1);
        send_byte(8'h3C);
        idle(3);
        // R5 boundary: nine ones do not sync, ten do
        for (int i = 0; i < 9; i++) send(1'b1);
        chk(status_port[7] == 1'b0, "R5 nine ones", status_port[7], 0);
        send(1'b0);
        for (int i = 0; i < 10; i++) send(1'b1);
        chk(status_port[7] == 1'b1, "R5 ten ones", status_port[7], 1);
        // R6: more ones keep sync, idle keeps it
        for (int i = 0; i < 5; i++) send(1'b1);
        idle(2);
        chk(status_port[7] == 1'b1, "R6 held", status_port[7], 1);
        // R7: zero ends sync and is bit 7 of the next byte
        send_byte(8'h52);
        chk(data_port == 8'h52, "R7 aligned byte", data_port, 8'h52);
        // full sweep of byte values with a sync mark in front of each group
        for (int v = 0; v < 256; v++) begin
            if ((v % 32) == 0) for (int i = 0; i < 12; i++) send(1'b1);
            send_byte(8'(v));
            if ((v % 7) == 0) idle(1);
        end
        // R1: reset mid-byte
        send(1'b1); send(1'b0); send(1'b1);
        do_reset();
        send_byte(8'h0F);
        chk(data_port == 8'h0F, "R1 restart after reset", data_port, 8'h0F);
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule